// File: doc/BRIEF.md
# Doorbell mailbox controller

This block lets two processors, called agent A and agent B, ring each other through three independent channels. Every channel holds two 32-bit doorbell words, one for each direction. A sender sets bits in the word it owns for transmitting. The receiver sees the same word in its receive window and gets a level interrupt for as long as any bit is set. The receiver clears the bits once it has handled them. The sender learns that its message was taken only by polling its transmit word until it reads zero. No interrupt is raised toward the sender.

Each agent has its own zero-wait APB slave port. The two ports see mirrored maps: the word one agent transmits through is the word the other agent receives through. Channel 0 is the low-priority channel, channel 1 is the high-priority channel, and channel 2 is a secure-only channel. A non-secure access to the secure channel returns a slave error and has no effect. A small identification block returns the part number.

Top module: `dbell_mailbox`

## Requirements
- R1: While reset is asserted, and right after it, every doorbell word is zero and every interrupt line is low.
- R2: A write to a set register ORs the written value into the addressed word. Set registers sit at group offset 0x8.
- R3: A write to a clear register clears every bit of the addressed word that is 1 in the written value. Clear registers sit at group offset 0x10.
- R4: The transmit word of one agent is the same storage as the receive word of the other. A committed write is visible on both windows in the same cycle.
- R5: `irq_b[c]` is high exactly while the A-to-B word of channel c is nonzero. `irq_a[c]` is high exactly while the B-to-A word of channel c is nonzero.
- R6: A sender reads its transmit status as nonzero until the receiver has cleared every bit, and reads zero afterwards.
- R7: The address map is as follows.
  - Channel groups start at 0x000 (channel 0), 0x020 (channel 1) and 0x200 (channel 2).
  - Within a group, the status word reads at offset 0x0.
  - An agent's receive group sits at the channel base, and its transmit group at the channel base plus 0x100.
- R8: An access with PPROT bit 1 set (non-secure) to any register of channel 2 reads zero, does not change any word, and returns PSLVERR high. Secure accesses to channel 2 behave like accesses to the other channels, with PSLVERR low.
- R9: Reads of set or clear addresses return zero. Reads of unmapped addresses return zero. Neither kind of read raises PSLVERR.
- R10: The identification registers at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the bytes 0x98, 0xB0, 0x1B and 0x00. Combined as the low 24 bits, these give part number 0x1BB098.
- R11: When both agents write the same word in one cycle, all set bits are applied first and all clear bits after them.
- R12: PREADY is always high, so every access completes in its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_psel | input | 1 | Agent A APB select |
| a_penable | input | 1 | Agent A APB enable (access phase) |
| a_pwrite | input | 1 | Agent A write strobe |
| a_paddr | input | ADDR_W | Agent A byte address |
| a_pwdata | input | DATA_W | Agent A write data |
| a_pprot | input | 3 | Agent A protection; bit 1 set means non-secure |
| a_prdata | output | DATA_W | Agent A read data |
| a_pready | output | 1 | Agent A ready, always high |
| a_pslverr | output | 1 | Agent A slave error |
| b_psel | input | 1 | Agent B APB select |
| b_penable | input | 1 | Agent B APB enable (access phase) |
| b_pwrite | input | 1 | Agent B write strobe |
| b_paddr | input | ADDR_W | Agent B byte address |
| b_pwdata | input | DATA_W | Agent B write data |
| b_pprot | input | 3 | Agent B protection; bit 1 set means non-secure |
| b_prdata | output | DATA_W | Agent B read data |
| b_pready | output | 1 | Agent B ready, always high |
| b_pslverr | output | 1 | Agent B slave error |
| irq_a | output | NCH | Per-channel doorbell interrupts toward agent A |
| irq_b | output | NCH | Per-channel doorbell interrupts toward agent B |

## Verification
The bench aims at cycles where both agents write the same word at once. A design that applied clear before set, or that let one port win, would leave the wrong bits standing. Non-secure probes of the secure channel must show zero data and an error, and a later secure read must show the word unchanged; a leaky design would show the probe's bits or a silent OK. Each channel is written through one window and read back through the mirrored window of the other agent, and the interrupt lines are compared after every access. These checks catch crossed channel bases, a transmit group at the wrong offset, or an interrupt sent to the sender instead of the receiver. Reads of set, clear, identification and unmapped addresses catch a decoder that aliases addresses or returns stale data.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
   localparam int GRP_RX   = 0;
   localparam int GRP_TX   = 1;
   localparam int NGRP     = 2;
   localparam int REG_STAT = 0;
   localparam int REG_SET  = 1;
   localparam int REG_CLR  = 2;
   localparam int NREG     = 3;
   localparam int TX_SHIFT = 'h100;
   localparam int PID_BASE = 'hFE0;
   localparam int NPID     = 4;

   // base of a channel's register group; the order is the priority order
   function automatic int chan_base(input int c);
      case (c)
         0:       return 'h000;
         1:       return 'h020;
         default: return 'h200;
      endcase
   endfunction

   // status, set and clear sit eight bytes apart
   function automatic int reg_addr(input int c, input int g, input int r);
      return chan_base(c) + g * TX_SHIFT + r * 8;
   endfunction
endpackage

// File: rtl/dbm_word.sv
module dbm_word #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_m,
   input  logic [W-1:0] clr_m,
   output logic [W-1:0] q
);
   // sets from either side land first, clears are applied on top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q | set_m) & ~clr_m;
   end
endmodule

// File: rtl/dbm_port.sv
module dbm_port
   import dbm_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter int          NCH     = 3,
   parameter int          SEC_CH  = 2,
   parameter logic [23:0] PART_ID = 24'h1BB098
) (
   input  logic                        psel,
   input  logic                        penable,
   input  logic                        pwrite,
   input  logic [ADDR_W-1:0]           paddr,
   input  logic [DATA_W-1:0]           pwdata,
   input  logic [2:0]                  pprot,
   output logic [DATA_W-1:0]           prdata,
   output logic                        pready,
   output logic                        pslverr,
   input  logic [NCH-1:0][DATA_W-1:0]  rx_word,
   input  logic [NCH-1:0][DATA_W-1:0]  tx_word,
   output logic [NCH-1:0][DATA_W-1:0]  rx_set,
   output logic [NCH-1:0][DATA_W-1:0]  rx_clr,
   output logic [NCH-1:0][DATA_W-1:0]  tx_set,
   output logic [NCH-1:0][DATA_W-1:0]  tx_clr
);
   localparam int PID_BYTES = 3;

   logic acc;
   logic rd_acc;
   logic wr_acc;
   logic nonsec;
   assign acc    = psel & penable;
   assign rd_acc = acc & ~pwrite;
   assign wr_acc = acc & pwrite;
   assign nonsec = pprot[1];

   logic [NCH-1:0]                      blk;
   logic [NCH-1:0]                      any_hit;
   logic [NCH-1:0][NGRP-1:0][NREG-1:0]  hit;
   logic [NCH-1:0][DATA_W-1:0]          chan_rd;
   logic [NPID-1:0][DATA_W-1:0]         pid_rd;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      if (c == SEC_CH) begin : g_sec
         assign blk[c] = nonsec;
      end else begin : g_open
         assign blk[c] = 1'b0;
      end

      for (genvar g = 0; g < NGRP; g++) begin : g_grp
         for (genvar r = 0; r < NREG; r++) begin : g_reg
            assign hit[c][g][r] = acc && (paddr == ADDR_W'(reg_addr(c, g, r)));
         end
      end

      assign any_hit[c] = |hit[c];

      assign rx_set[c] = (wr_acc && hit[c][GRP_RX][REG_SET] && !blk[c]) ? pwdata : '0;
      assign rx_clr[c] = (wr_acc && hit[c][GRP_RX][REG_CLR] && !blk[c]) ? pwdata : '0;
      assign tx_set[c] = (wr_acc && hit[c][GRP_TX][REG_SET] && !blk[c]) ? pwdata : '0;
      assign tx_clr[c] = (wr_acc && hit[c][GRP_TX][REG_CLR] && !blk[c]) ? pwdata : '0;

      always_comb begin
         chan_rd[c] = '0;
         if (!pwrite && !blk[c]) begin
            if (hit[c][GRP_RX][REG_STAT]) chan_rd[c] = rx_word[c];
            if (hit[c][GRP_TX][REG_STAT]) chan_rd[c] = tx_word[c];
         end
      end
   end

   for (genvar k = 0; k < NPID; k++) begin : g_pid
      logic pid_hit;
      assign pid_hit = rd_acc && (paddr == ADDR_W'(PID_BASE + 4 * k));
      if (k < PID_BYTES) begin : g_byte
         assign pid_rd[k] = pid_hit ? DATA_W'(PART_ID[8*k +: 8]) : '0;
      end else begin : g_zero
         assign pid_rd[k] = '0;
      end
   end

   always_comb begin
      prdata = '0;
      for (int c = 0; c < NCH; c++)  prdata |= chan_rd[c];
      for (int k = 0; k < NPID; k++) prdata |= pid_rd[k];
   end

   assign pslverr = acc && |(blk & any_hit);
   assign pready  = 1'b1;
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
   import dbm_pkg::*;
#(
   parameter int          ADDR_W  = 12,
   parameter int          DATA_W  = 32,
   parameter int          NCH     = 3,
   parameter int          SEC_CH  = 2,
   parameter logic [23:0] PART_ID = 24'h1BB098
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_psel,
   input  logic              a_penable,
   input  logic              a_pwrite,
   input  logic [ADDR_W-1:0] a_paddr,
   input  logic [DATA_W-1:0] a_pwdata,
   input  logic [2:0]        a_pprot,
   output logic [DATA_W-1:0] a_prdata,
   output logic              a_pready,
   output logic              a_pslverr,
   input  logic              b_psel,
   input  logic              b_penable,
   input  logic              b_pwrite,
   input  logic [ADDR_W-1:0] b_paddr,
   input  logic [DATA_W-1:0] b_pwdata,
   input  logic [2:0]        b_pprot,
   output logic [DATA_W-1:0] b_prdata,
   output logic              b_pready,
   output logic              b_pslverr,
   output logic [NCH-1:0]    irq_a,
   output logic [NCH-1:0]    irq_b
);
   if (ADDR_W < 12) begin : g_bad_addr
      $error("dbell_mailbox: ADDR_W must cover a 4 KB window");
   end
   if (NCH < 1 || NCH > 3) begin : g_bad_nch
      $error("dbell_mailbox: NCH must be 1 to 3");
   end
   if (SEC_CH >= NCH) begin : g_bad_sec
      $error("dbell_mailbox: SEC_CH must name an existing channel");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("dbell_mailbox: DATA_W must hold an ID byte");
   end

   // word_ab: A transmits, B receives; word_ba the other way
   logic [NCH-1:0][DATA_W-1:0] word_ab, word_ba;
   logic [NCH-1:0][DATA_W-1:0] a_rx_set, a_rx_clr, a_tx_set, a_tx_clr;
   logic [NCH-1:0][DATA_W-1:0] b_rx_set, b_rx_clr, b_tx_set, b_tx_clr;

   dbm_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .SEC_CH(SEC_CH), .PART_ID(PART_ID)
   ) u_port_a (
      .psel(a_psel), .penable(a_penable), .pwrite(a_pwrite), .paddr(a_paddr),
      .pwdata(a_pwdata), .pprot(a_pprot), .prdata(a_prdata), .pready(a_pready),
      .pslverr(a_pslverr), .rx_word(word_ba), .tx_word(word_ab),
      .rx_set(a_rx_set), .rx_clr(a_rx_clr), .tx_set(a_tx_set), .tx_clr(a_tx_clr)
   );

   dbm_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .SEC_CH(SEC_CH), .PART_ID(PART_ID)
   ) u_port_b (
      .psel(b_psel), .penable(b_penable), .pwrite(b_pwrite), .paddr(b_paddr),
      .pwdata(b_pwdata), .pprot(b_pprot), .prdata(b_prdata), .pready(b_pready),
      .pslverr(b_pslverr), .rx_word(word_ab), .tx_word(word_ba),
      .rx_set(b_rx_set), .rx_clr(b_rx_clr), .tx_set(b_tx_set), .tx_clr(b_tx_clr)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_store
      dbm_word #(.W(DATA_W)) u_ab (
         .clk(clk), .rst_n(rst_n),
         .set_m(a_tx_set[c] | b_rx_set[c]),
         .clr_m(a_tx_clr[c] | b_rx_clr[c]),
         .q(word_ab[c])
      );
      dbm_word #(.W(DATA_W)) u_ba (
         .clk(clk), .rst_n(rst_n),
         .set_m(b_tx_set[c] | a_rx_set[c]),
         .clr_m(b_tx_clr[c] | a_rx_clr[c]),
         .q(word_ba[c])
      );
      assign irq_b[c] = |word_ab[c];
      assign irq_a[c] = |word_ba[c];
   end
endmodule

// File: rtl/dbm_chk.sv
module dbm_chk
   import dbm_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 32,
   parameter int NCH    = 3,
   parameter int SEC_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_psel,
   input logic              a_penable,
   input logic              a_pwrite,
   input logic [ADDR_W-1:0] a_paddr,
   input logic [DATA_W-1:0] a_pwdata,
   input logic [2:0]        a_pprot,
   input logic [DATA_W-1:0] a_prdata,
   input logic              a_pready,
   input logic              a_pslverr,
   input logic              b_psel,
   input logic              b_penable,
   input logic              b_pwrite,
   input logic [ADDR_W-1:0] b_paddr,
   input logic [DATA_W-1:0] b_pwdata,
   input logic [2:0]        b_pprot,
   input logic [DATA_W-1:0] b_prdata,
   input logic              b_pready,
   input logic              b_pslverr,
   input logic [NCH-1:0]    irq_a,
   input logic [NCH-1:0]    irq_b
);
   function automatic logic in_sec(input logic [ADDR_W-1:0] ad);
      logic h;
      h = 1'b0;
      for (int g = 0; g < NGRP; g++)
         for (int r = 0; r < NREG; r++)
            if (ad == ADDR_W'(reg_addr(SEC_CH, g, r))) h = 1'b1;
      return h;
   endfunction

   logic a_wr, b_wr;
   assign a_wr = a_psel & a_penable & a_pwrite;
   assign b_wr = b_psel & b_penable & b_pwrite;

   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (irq_a == '0 && irq_b == '0);
      end
   end

   // R8
   a_sec_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_psel && a_penable && a_pprot[1] && in_sec(a_paddr)) |-> a_pslverr);

   // R8
   b_sec_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_psel && b_penable && b_pprot[1] && in_sec(b_paddr)) |-> b_pslverr);

   // R8
   sec_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_psel && a_penable && !a_pprot[1]) |-> !a_pslverr);

   // R8
   sec_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && a_pprot[1] && in_sec(a_paddr) && !b_wr)
      |=> ($stable(irq_a[SEC_CH]) && $stable(irq_b[SEC_CH])));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      // R2
      set_rings_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (a_wr && a_paddr == ADDR_W'(reg_addr(c, GRP_TX, REG_SET)) && a_pwdata != '0
          && !(c == SEC_CH && a_pprot[1]) && !b_wr) |=> irq_b[c]);

      // R3
      clear_quiets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (b_wr && b_paddr == ADDR_W'(reg_addr(c, GRP_RX, REG_CLR)) && (&b_pwdata)
          && !(c == SEC_CH && b_pprot[1]) && !a_wr) |=> !irq_b[c]);
   end
endmodule

bind dbell_mailbox dbm_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .SEC_CH(SEC_CH)
) u_chk (.*);

// File: tb/dbell_mailbox_test.sv
module dbell_mailbox_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        a_psel = 0, a_penable = 0, a_pwrite = 0;
   logic [11:0] a_paddr = '0;
   logic [31:0] a_pwdata = '0;
   logic [2:0]  a_pprot = '0;
   logic [31:0] a_prdata;
   logic        a_pready, a_pslverr;
   logic        b_psel = 0, b_penable = 0, b_pwrite = 0;
   logic [11:0] b_paddr = '0;
   logic [31:0] b_pwdata = '0;
   logic [2:0]  b_pprot = '0;
   logic [31:0] b_prdata;
   logic        b_pready, b_pslverr;
   logic [2:0]  irq_a, irq_b;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   localparam logic [2:0] SEC = 3'b000;
   localparam logic [2:0] NSEC = 3'b010;

   always #4 clk = ~clk;

   dbell_mailbox uut (
      .clk(clk), .rst_n(rst_n),
      .a_psel(a_psel), .a_penable(a_penable), .a_pwrite(a_pwrite), .a_paddr(a_paddr),
      .a_pwdata(a_pwdata), .a_pprot(a_pprot), .a_prdata(a_prdata), .a_pready(a_pready),
      .a_pslverr(a_pslverr),
      .b_psel(b_psel), .b_penable(b_penable), .b_pwrite(b_pwrite), .b_paddr(b_paddr),
      .b_pwdata(b_pwdata), .b_pprot(b_pprot), .b_prdata(b_prdata), .b_pready(b_pready),
      .b_pslverr(b_pslverr),
      .irq_a(irq_a), .irq_b(irq_b)
   );

   // ---------------- reference model ----------------
   logic [31:0] m_ab [3];
   logic [31:0] m_ba [3];
   logic [31:0] s_ab [3], c_ab [3], s_ba [3], c_ba [3];

   function automatic logic [11:0] baddr(input int c, input int g, input int r);
      int b;
      b = (c == 0) ? 'h000 : (c == 1) ? 'h020 : 'h200;
      return 12'(b + g * 'h100 + r * 8);
   endfunction

   function automatic bit decode(input logic [11:0] ad, output int ch, output int g, output int r);
      ch = 0; g = 0; r = 0;
      for (int cc = 0; cc < 3; cc++)
         for (int gg = 0; gg < 2; gg++)
            for (int rr = 0; rr < 3; rr++)
               if (ad == baddr(cc, gg, rr)) begin
                  ch = cc; g = gg; r = rr;
                  return 1'b1;
               end
      return 1'b0;
   endfunction

   function automatic logic [31:0] exp_read(input bit ag, input logic [11:0] ad, input logic [2:0] pr);
      int ch, g, r;
      if (decode(ad, ch, g, r)) begin
         if (ch == 2 && pr[1]) return '0;
         if (r != 0) return '0;
         return (int'(ag) != g) ? m_ab[ch] : m_ba[ch];
      end
      case (ad)
         12'hFE0: return 32'h98;
         12'hFE4: return 32'hB0;
         12'hFE8: return 32'h1B;
         default: return '0;
      endcase
   endfunction

   function automatic bit exp_err(input logic [11:0] ad, input logic [2:0] pr);
      int ch, g, r;
      return decode(ad, ch, g, r) && ch == 2 && pr[1];
   endfunction

   task automatic model_clear_masks();
      for (int c = 0; c < 3; c++) begin
         s_ab[c] = '0; c_ab[c] = '0; s_ba[c] = '0; c_ba[c] = '0;
      end
   endtask

   task automatic model_write(input bit ag, input logic [11:0] ad, input logic [31:0] d, input logic [2:0] pr);
      int ch, g, r;
      if (decode(ad, ch, g, r) && !(ch == 2 && pr[1]) && r != 0) begin
         if (int'(ag) != g) begin
            if (r == 1) s_ab[ch] |= d; else c_ab[ch] |= d;
         end else begin
            if (r == 1) s_ba[ch] |= d; else c_ba[ch] |= d;
         end
      end
   endtask

   task automatic model_commit();
      for (int c = 0; c < 3; c++) begin
         m_ab[c] = (m_ab[c] | s_ab[c]) & ~c_ab[c];
         m_ba[c] = (m_ba[c] | s_ba[c]) & ~c_ba[c];
      end
      model_clear_masks();
   endtask

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic chk_irq(input string req);
      logic [2:0] ea, eb;
      for (int c = 0; c < 3; c++) begin
         ea[c] = (m_ba[c] != 0);
         eb[c] = (m_ab[c] != 0);
      end
      chk(req, {29'd0, irq_a}, {29'd0, ea});
      chk(req, {29'd0, irq_b}, {29'd0, eb});
   endtask

   // ---------------- APB driver ----------------
   task automatic access(input bit ag, input bit wr, input logic [11:0] ad, input logic [31:0] d,
                         input logic [2:0] pr, output logic [31:0] rd, output logic err, output logic rdy);
      @(negedge clk);
      if (!ag) begin
         a_psel = 1; a_penable = 0; a_pwrite = wr; a_paddr = ad; a_pwdata = d; a_pprot = pr;
      end else begin
         b_psel = 1; b_penable = 0; b_pwrite = wr; b_paddr = ad; b_pwdata = d; b_pprot = pr;
      end
      @(negedge clk);
      if (!ag) a_penable = 1; else b_penable = 1;
      #1;
      rd  = ag ? b_prdata  : a_prdata;
      err = ag ? b_pslverr : a_pslverr;
      rdy = ag ? b_pready  : a_pready;
      @(negedge clk);
      if (!ag) begin a_psel = 0; a_penable = 0; end
      else     begin b_psel = 0; b_penable = 0; end
      #1;
   endtask

   task automatic op(input bit ag, input bit wr, input logic [11:0] ad, input logic [31:0] d,
                     input logic [2:0] pr, input string tag);
      logic [31:0] rd, er;
      logic err, rdy;
      bit ee;
      er = exp_read(ag, ad, pr);
      ee = exp_err(ad, pr);
      access(ag, wr, ad, d, pr, rd, err, rdy);
      if (wr) model_write(ag, ad, d, pr);
      model_commit();
      if (!wr) chk(tag, rd, er);
      chk(ee ? "R8" : "R9", {31'd0, err}, {31'd0, ee});
      chk("R12", {31'd0, rdy}, 32'd1);
      chk_irq("R5");
   endtask

   task automatic dual(input logic [11:0] ad_a, input logic [31:0] d_a, input logic [2:0] p_a,
                       input logic [11:0] ad_b, input logic [31:0] d_b, input logic [2:0] p_b);
      logic [31:0] ra, rb;
      logic ea, eb, ya, yb;
      fork
         access(1'b0, 1'b1, ad_a, d_a, p_a, ra, ea, ya);
         access(1'b1, 1'b1, ad_b, d_b, p_b, rb, eb, yb);
      join
      model_write(1'b0, ad_a, d_a, p_a);
      model_write(1'b1, ad_b, d_b, p_b);
      model_commit();
      chk("R11", {31'd0, ea}, {31'd0, exp_err(ad_a, p_a)});
      chk("R11", {31'd0, eb}, {31'd0, exp_err(ad_b, p_b)});
      chk_irq("R5");
   endtask

   task automatic read_all(input string tag);
      for (int c = 0; c < 3; c++)
         for (int g = 0; g < 2; g++) begin
            op(1'b0, 1'b0, baddr(c, g, 0), '0, SEC, tag);
            op(1'b1, 1'b0, baddr(c, g, 0), '0, SEC, tag);
         end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0;
      for (int c = 0; c < 3; c++) begin m_ab[c] = '0; m_ba[c] = '0; end
      model_clear_masks();
      repeat (3) @(negedge clk);
      #1;
      chk("R1", {26'd0, irq_a, irq_b}, 32'd0);
      rst_n = 1;
   endtask

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] rd;
      logic err, rdy;
      int c, g, r;
      bit ag;
      logic [2:0] pr;
      logic [31:0] d;

      void'($urandom(32'd20240611));
      do_reset();

      // R1: everything reads zero after reset
      read_all("R1");

      // R7 / R4 / R2: each channel written through A's transmit window,
      // seen on B's receive window at the channel base
      for (int ch = 0; ch < 3; ch++) begin
         op(1'b0, 1'b1, baddr(ch, 1, 1), 32'h1 << (ch + 4), SEC, "R2");
         op(1'b1, 1'b0, baddr(ch, 0, 0), '0, SEC, "R7");
         op(1'b0, 1'b0, baddr(ch, 1, 0), '0, SEC, "R4");
         op(1'b0, 1'b0, baddr(ch, 0, 0), '0, SEC, "R7");
      end
      // literal expectation of the mirror for channel 1 (offset 0x020)
      access(1'b1, 1'b0, 12'h020, '0, SEC, rd, err, rdy);
      chk("R7", rd, 32'h0000_0020);

      // R2: OR-in keeps earlier bits
      op(1'b0, 1'b1, 12'h108, 32'h0000_0300, SEC, "R2");
      access(1'b1, 1'b0, 12'h000, '0, SEC, rd, err, rdy);
      chk("R2", rd, 32'h0000_0310);

      // R3: partial clear from the receiver
      op(1'b1, 1'b1, 12'h010, 32'h0000_0100, SEC, "R3");
      access(1'b0, 1'b0, 12'h100, '0, SEC, rd, err, rdy);
      chk("R3", rd, 32'h0000_0210);

      // R9: write-only and unmapped addresses
      op(1'b0, 1'b0, 12'h108, '0, SEC, "R9");
      op(1'b0, 1'b0, 12'h110, '0, SEC, "R9");
      op(1'b1, 1'b0, 12'h008, '0, SEC, "R9");
      op(1'b0, 1'b0, 12'h040, '0, SEC, "R9");
      op(1'b1, 1'b0, 12'h1FC, '0, NSEC, "R9");

      // R10: identification bytes
      op(1'b0, 1'b0, 12'hFE0, '0, SEC, "R10");
      op(1'b0, 1'b0, 12'hFE4, '0, SEC, "R10");
      op(1'b1, 1'b0, 12'hFE8, '0, NSEC, "R10");
      op(1'b1, 1'b0, 12'hFEC, '0, SEC, "R10");
      begin
         logic [31:0] p0, p1, p2;
         access(1'b0, 1'b0, 12'hFE0, '0, SEC, p0, err, rdy);
         access(1'b0, 1'b0, 12'hFE4, '0, SEC, p1, err, rdy);
         access(1'b0, 1'b0, 12'hFE8, '0, SEC, p2, err, rdy);
         chk("R10", {8'd0, p2[7:0], p1[7:0], p0[7:0]}, 32'h001B_B098);
      end

      // R8: non-secure probes of the secure channel
      op(1'b0, 1'b1, 12'h308, 32'hDEAD_0000, NSEC, "R8");
      access(1'b1, 1'b0, 12'h200, '0, SEC, rd, err, rdy);
      chk("R8", rd, 32'h0000_0040);
      chk("R8", {31'd0, err}, 32'd0);
      access(1'b1, 1'b0, 12'h200, '0, NSEC, rd, err, rdy);
      chk("R8", rd, 32'd0);
      chk("R8", {31'd0, err}, 32'd1);
      op(1'b1, 1'b1, 12'h210, 32'hFFFF_FFFF, NSEC, "R8");
      chk("R8", {31'd0, irq_b[2]}, 32'd1);
      op(1'b1, 1'b1, 12'h210, 32'hFFFF_FFFF, SEC, "R8");

      // R11: same word, same cycle, set then clear
      op(1'b1, 1'b1, 12'h030, 32'hFFFF_FFFF, SEC, "R3");
      dual(12'h128, 32'h00FF_00FF, SEC, 12'h030, 32'h0F0F_0F0F, SEC);
      access(1'b1, 1'b0, 12'h020, '0, SEC, rd, err, rdy);
      chk("R11", rd, 32'h00F0_00F0);
      dual(12'h128, 32'h0000_F000, SEC, 12'h028, 32'h000F_0000, SEC);
      access(1'b0, 1'b0, 12'h120, '0, SEC, rd, err, rdy);
      chk("R11", rd, 32'h00FF_F0F0);

      // R6: B rings A on channel 0 and polls for completion
      op(1'b1, 1'b1, 12'h108, 32'h0000_0005, SEC, "R2");
      chk("R6", {31'd0, irq_a[0]}, 32'd1);
      op(1'b1, 1'b0, 12'h100, '0, SEC, "R6");
      op(1'b0, 1'b1, 12'h010, 32'h0000_0001, SEC, "R3");
      access(1'b1, 1'b0, 12'h100, '0, SEC, rd, err, rdy);
      chk("R6", rd, 32'h0000_0004);
      op(1'b0, 1'b1, 12'h010, 32'h0000_0004, SEC, "R3");
      access(1'b1, 1'b0, 12'h100, '0, SEC, rd, err, rdy);
      chk("R6", rd, 32'd0);
      chk("R6", {31'd0, irq_a[0]}, 32'd0);

      // constrained random traffic
      for (int i = 0; i < 400; i++) begin
         c  = $urandom_range(2, 0);
         g  = $urandom_range(1, 0);
         r  = $urandom_range(2, 0);
         ag = 1'($urandom_range(1, 0));
         pr = ($urandom_range(3, 0) == 0) ? NSEC : SEC;
         d  = $urandom() & $urandom();
         if (r == 2 && $urandom_range(1, 0) == 1)
            d = (int'(ag) != g) ? m_ab[c] : m_ba[c];
         if (i % 5 == 4) begin
            dual(baddr(c, g, (r == 0) ? 1 : r), d, pr,
                 baddr(c, 1 - g, $urandom_range(2, 1)), $urandom(), SEC);
            op(1'b1, 1'b0, baddr(c, g, 0), '0, SEC, "R11");
         end else begin
            op(ag, (r != 0), baddr(c, g, r), d, pr, (r == 0) ? "R4" : "R9");
         end
         if (i % 50 == 49) read_all("R4");
      end

      // R1: reset in the middle of traffic
      op(1'b0, 1'b1, 12'h128, 32'h8000_0001, SEC, "R2");
      do_reset();
      read_all("R1");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule